// File: doc/BRIEF.md
# Byte-Laned Asynchronous SRAM Controller

This block sits between an internal request bus and a 16-bit asynchronous static RAM. It takes one read or write at a time, with a word address, a two-bit lane mask and write data, and steps the memory pins through a fixed sequence of phases: address setup, read access or write pulse, then recovery. The memory has two chip selects of opposite polarity, an output enable, a write enable and a low-active enable for each byte lane. A write happens only while all of the selecting strobes overlap. Every output pin comes from a register.

Each phase lasts a programmable number of clock cycles, set on the `cfg_*` inputs. This lets one build of the controller meet the setup, access, pulse-width and recovery times of faster and slower memory grades. The data bus is split into an output value, a per-lane output enable and an input value. Tri-state buffers at the chip pads join these three. Read data comes back with a one-cycle response pulse, and the lanes that were not requested read as zero.

Top module: `sram_ctrl`

## Requirements
- R1: While idle (`req_ready` high) the controller holds `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1 and drives no data lane. The same state holds after reset.
- R2: `req_ready` is high only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` returns high once the whole sequence is finished.
- R3: After a request is accepted, the controller selects the memory for `cfg_setup` cycles before any strobe. Selected means `mem_ce1_n`=0 and `mem_ce2`=1, with the byte enables set from the mask and with `mem_oe_n`=1 and `mem_we_n`=1.
- R4: A read holds `mem_oe_n` low for `cfg_access` cycles. `rsp_valid` then pulses for exactly one cycle, in the cycle that follows the last access cycle.
- R5: A write holds `mem_oe_n` high throughout. It keeps `mem_we_n` low for `cfg_turn` + `cfg_wpulse` cycles while the memory stays selected.
- R6: During a write, data lanes are driven only after `mem_we_n` has been low for `cfg_turn` cycles. Driving lasts `cfg_wpulse` cycles plus one cycle after `mem_we_n` returns high, and then the bus is released.
- R7: After the access phase or the write pulse, all strobes and byte enables go inactive together. `mem_addr` is then held for `cfg_recov` cycles before the controller returns to idle.
- R8: A request whose mask is `2'b00` asserts no strobe and returns to idle two cycles after acceptance. If it is a read, it pulses `rsp_valid` with zero data in that cycle.
- R9: A count of zero on any `cfg_*` input is treated as one cycle.
- R10: Mask bit 0 selects the lower lane: `mem_lb_n` and `dq[7:0]`. Mask bit 1 selects the upper lane: `mem_ub_n` and `dq[15:8]`. A masked write changes only the selected lanes of memory. A read returns the selected lanes and zero in the others.
- R11: `mem_addr` does not change on any cycle where the memory was selected in both that cycle and the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | 21 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane mask, bit 0 lower, bit 1 upper |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| cfg_setup | input | 6 | Address setup cycles |
| cfg_access | input | 6 | Read access cycles |
| cfg_turn | input | 6 | Write-enable-to-drive turnaround cycles |
| cfg_wpulse | input | 6 | Write drive cycles |
| cfg_recov | input | 6 | Recovery cycles |
| mem_addr | output | 21 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 2 | Per-lane drive enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Any fault in the phase sequencing shows up in the number of cycles each strobe stays low. It appears within the transaction that causes it, because every phase length is compared cycle by cycle against the programmed counts. A bad lane mapping or a bad capture register gives wrong read-back data in the very next read of that address. A driver left enabled, or enabled too early, shows up on `mem_dq_oe` in the same cycle. The recovery hold and the return of `req_ready` give away a late or early exit from recovery at the end of each access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_NULL,
    PH_SETUP,
    PH_ACCESS,
    PH_WTURN,
    PH_WDRIVE,
    PH_RECOV
  } phase_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic sel;
  } strobe_t;

  function automatic strobe_t strobe_of(phase_e p);
    strobe_t s;
    s = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, sel: 1'b0};
    case (p)
      PH_SETUP:  s = '{ce1_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, sel: 1'b1};
      PH_ACCESS: s = '{ce1_n: 1'b0, ce2: 1'b1, oe_n: 1'b0, we_n: 1'b1, sel: 1'b1};
      PH_WTURN,
      PH_WDRIVE: s = '{ce1_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b0, sel: 1'b1};
      default:   s = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, sel: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign last = (remain <= CNT_W'(1));
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              capture,
  input  logic              drive,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       oe_q;
    logic [7:0] out_q;
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        oe_q  <= 1'b0;
        out_q <= '0;
        rd_q  <= '0;
      end else begin
        oe_q  <= drive & mask[g];
        out_q <= wdata[g*8 +: 8];
        if (capture) begin
          rd_q <= mask[g] ? dq_in[g*8 +: 8] : 8'h00;
        end
      end
    end

    assign dq_oe[g]          = oe_q;
    assign dq_out[g*8 +: 8]  = out_q;
    assign rdata[g*8 +: 8]   = rd_q;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_access,
  input  logic [CNT_W-1:0]  cfg_turn,
  input  logic [CNT_W-1:0]  cfg_wpulse,
  input  logic [CNT_W-1:0]  cfg_recov,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [LANES-1:0]  mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  phase_e             ph, ph_nxt;
  logic               lat_we;
  logic [LANES-1:0]   lat_mask;
  logic [DATA_W-1:0]  lat_wdata;
  logic               accept;
  logic               ph_last;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic [LANES-1:0]   mask_nxt;
  logic               capture;
  logic               drive;
  strobe_t            stb_nxt;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid & req_ready;

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE:   if (req_valid) ph_nxt = (req_mask == '0) ? PH_NULL : PH_SETUP;
      PH_NULL:   ph_nxt = PH_IDLE;
      PH_SETUP:  if (ph_last) ph_nxt = lat_we ? PH_WTURN : PH_ACCESS;
      PH_ACCESS: if (ph_last) ph_nxt = PH_RECOV;
      PH_WTURN:  if (ph_last) ph_nxt = PH_WDRIVE;
      PH_WDRIVE: if (ph_last) ph_nxt = PH_RECOV;
      PH_RECOV:  if (ph_last) ph_nxt = PH_IDLE;
      default:   ph_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (ph_nxt)
      PH_SETUP:  tmr_val = cfg_setup;
      PH_ACCESS: tmr_val = cfg_access;
      PH_WTURN:  tmr_val = cfg_turn;
      PH_WDRIVE: tmr_val = cfg_wpulse;
      PH_RECOV:  tmr_val = cfg_recov;
      default:   tmr_val = CNT_W'(1);
    endcase
  end

  assign tmr_load = (ph_nxt != ph);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (ph_last)
  );

  assign mask_nxt = accept ? req_mask : lat_mask;
  assign stb_nxt  = strobe_of(ph_nxt);
  assign capture  = ((ph == PH_ACCESS) && ph_last) || ((ph == PH_NULL) && !lat_we);
  assign drive    = (ph_nxt == PH_WDRIVE) || (ph == PH_WDRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      lat_we    <= 1'b0;
      lat_mask  <= '0;
      lat_wdata <= '0;
      mem_addr  <= '0;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      ph        <= ph_nxt;
      if (accept) begin
        lat_we    <= req_we;
        lat_mask  <= req_mask;
        lat_wdata <= req_wdata;
        mem_addr  <= req_addr;
      end
      mem_ce1_n <= stb_nxt.ce1_n;
      mem_ce2   <= stb_nxt.ce2;
      mem_oe_n  <= stb_nxt.oe_n;
      mem_we_n  <= stb_nxt.we_n;
      mem_lb_n  <= ~(stb_nxt.sel & mask_nxt[0]);
      mem_ub_n  <= ~(stb_nxt.sel & mask_nxt[LANES-1]);
      rsp_valid <= capture;
    end
  end

  sram_lane_io #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .mask    (lat_mask),
    .wdata   (lat_wdata),
    .dq_in   (mem_dq_in),
    .capture (capture),
    .drive   (drive),
    .dq_out  (mem_dq_out),
    .dq_oe   (mem_dq_oe),
    .rdata   (rsp_rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [LANES-1:0]  mem_dq_oe
);
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_dq_oe == '0));

  // R5
  write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce1_n && mem_ce2 && !(mem_lb_n && mem_ub_n)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> (mem_dq_oe == '0));

  // R6
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe != '0) |-> (!mem_we_n || $past(!mem_we_n)));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_dq_oe == '0));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_mask = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [5:0]  cfg_setup = 6'd2, cfg_access = 6'd3, cfg_turn = 6'd1, cfg_wpulse = 6'd2, cfg_recov = 6'd2;
  logic [20:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_in;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sram_ctrl dut (.*);

  logic [15:0] marr [256];
  logic        sel_m;
  assign sel_m = !mem_ce1_n && mem_ce2;
  assign mem_dq_in[7:0]  = (sel_m && !mem_oe_n && mem_we_n && !mem_lb_n) ? marr[mem_addr[7:0]][7:0]  : 8'hA5;
  assign mem_dq_in[15:8] = (sel_m && !mem_oe_n && mem_we_n && !mem_ub_n) ? marr[mem_addr[7:0]][15:8] : 8'h5A;

  always @(posedge clk) begin
    if (sel_m && !mem_we_n) begin
      if (!mem_lb_n && mem_dq_oe[0]) marr[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n && mem_dq_oe[1]) marr[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int eff(input logic [5:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // results of the last transaction
  int n_exit, n_setup, n_oe, n_we, n_drive, we_at_first_drive, n_recov, rsp_at, rsp_cnt;
  int bad_addr, bad_lane, oe_in_we, any_strobe;
  logic [15:0] rsp_seen;

  task automatic run_req(input bit we, input logic [20:0] a, input logic [1:0] m, input logic [15:0] d);
    int n = 0;
    bit struck = 0;
    n_setup = 0; n_oe = 0; n_we = 0; n_drive = 0; we_at_first_drive = -1; n_recov = 0;
    rsp_at = -1; rsp_cnt = 0; bad_addr = 0; bad_lane = 0; oe_in_we = 0; any_strobe = 0; rsp_seen = '0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_mask = m; req_wdata = d;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (!mem_ce1_n || mem_ce2 || !mem_oe_n || !mem_we_n || !mem_lb_n || !mem_ub_n) any_strobe++;
      if (sel_m && mem_oe_n && mem_we_n && !struck) n_setup++;
      if (!mem_oe_n) begin n_oe++; struck = 1; end
      if (!mem_we_n) begin n_we++; struck = 1; if (!mem_oe_n) oe_in_we++; end
      if (mem_dq_oe != 0) begin
        n_drive++;
        if (we_at_first_drive < 0) we_at_first_drive = n_we;
      end
      if (struck && !sel_m && !req_ready) n_recov++;
      if (!req_ready && mem_addr != a) bad_addr++;
      if (sel_m && (mem_lb_n != !m[0] || mem_ub_n != !m[1])) bad_lane++;
      if (rsp_valid) begin rsp_cnt++; rsp_at = n; rsp_seen = rsp_rdata; end
      if (req_ready) break;
      if (n > 500) break;
    end
    n_exit = n;
  endtask

  task automatic t_reset;
    chk(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
        && mem_dq_oe == 0 && !rsp_valid, "R1 reset idle", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);
  endtask

  task automatic t_write(input logic [20:0] a, input logic [1:0] m, input logic [15:0] d);
    int s = eff(cfg_setup), t = eff(cfg_turn), w = eff(cfg_wpulse), r = eff(cfg_recov);
    run_req(1'b1, a, m, d);
    chk(n_setup == s, "R3 write setup cycles", n_setup, s);
    chk(n_we == t + w, "R5 we low cycles", n_we, t + w);
    chk(oe_in_we == 0 && n_oe == 0, "R5 oe high in write", n_oe, 0);
    chk(n_drive == w + 1, "R6 drive cycles", n_drive, w + 1);
    chk(we_at_first_drive == t + 1, "R6 turnaround before drive", we_at_first_drive, t + 1);
    chk(n_recov == r, "R7 recovery cycles", n_recov, r);
    chk(bad_addr == 0, "R11 address held", bad_addr, 0);
    chk(bad_lane == 0, "R10 byte enables", bad_lane, 0);
    chk(n_exit == s + t + w + r + 1, "R2 ready return write", n_exit, s + t + w + r + 1);
  endtask

  task automatic t_read(input logic [20:0] a, input logic [1:0] m, input logic [15:0] exp);
    int s = eff(cfg_setup), ac = eff(cfg_access), r = eff(cfg_recov);
    run_req(1'b0, a, m, 16'h0);
    chk(n_setup == s, "R3 read setup cycles", n_setup, s);
    chk(n_oe == ac && n_we == 0, "R4 oe low cycles", n_oe, ac);
    chk(rsp_cnt == 1 && rsp_at == s + ac + 1, "R4 response timing", rsp_at, s + ac + 1);
    chk(rsp_seen == exp, "R10 read data", rsp_seen, exp);
    chk(n_drive == 0, "R4 no drive on read", n_drive, 0);
    chk(n_recov == r, "R7 read recovery", n_recov, r);
    chk(n_exit == s + ac + r + 1, "R2 ready return read", n_exit, s + ac + r + 1);
  endtask

  task automatic t_empty_mask;
    run_req(1'b1, 21'h10, 2'b00, 16'hDEAD);
    chk(any_strobe == 0 && n_drive == 0, "R8 empty write no strobe", any_strobe, 0);
    chk(n_exit == 2, "R8 empty write length", n_exit, 2);
    run_req(1'b0, 21'h10, 2'b00, 16'h0);
    chk(any_strobe == 0, "R8 empty read no strobe", any_strobe, 0);
    chk(rsp_cnt == 1 && rsp_at == 2 && rsp_seen == 16'h0, "R8 empty read response", rsp_at, 2);
    t_read(21'h10, 2'b11, 16'h1357);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // word write and read back
    t_write(21'h10, 2'b11, 16'h1357);
    t_read(21'h10, 2'b11, 16'h1357);
    // lower-lane write leaves upper lane
    t_write(21'h22, 2'b11, 16'hAAAA);
    t_write(21'h22, 2'b01, 16'h55C3);
    t_read(21'h22, 2'b11, 16'hAAC3);
    // single-lane reads zero the other lane
    t_read(21'h22, 2'b10, 16'hAA00);
    t_read(21'h22, 2'b01, 16'h00C3);
    // R8
    t_empty_mask();
    // R9 zero counts behave as one
    cfg_setup = 0; cfg_access = 0; cfg_turn = 0; cfg_wpulse = 0; cfg_recov = 0;
    t_write(21'h1F_FF33, 2'b10, 16'h9900);
    t_read(21'h1F_FF33, 2'b10, 16'h9900);
    // slower grade timing
    cfg_setup = 3; cfg_access = 5; cfg_turn = 2; cfg_wpulse = 4; cfg_recov = 3;
    t_write(21'h44, 2'b11, 16'hBEEF);
    t_read(21'h44, 2'b11, 16'hBEEF);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule